// File: doc/BRIEF.md
# Serial Clock and Chip-Select Controller

This block paces the bit timing of a flash-oriented SPI master. From the reference clock it derives the serial clock, using a prescaler whose 3-bit code selects a divide ratio of 2, 4, 8 and so on up to 256. The serial clock is never faster than half the reference rate. The block also produces one-cycle launch and sample strobes for a separate shift engine, and drives two active-low chip-select lines. Those lines serve a lower and an upper memory when two devices share the bus.

Each byte is 8 bits, which is 16 serial-clock edges. A byte begins when the shift engine holds `byte_req` high, the block is enabled, and any manual-start condition is met. When a byte begins, the block latches the divisor code, the polarity and the phase, and it keeps them unchanged until the byte ends. The chip select can follow the transfer on its own, or it can be forced from a control input. In manual-start mode, queued bytes wait until a start pulse is given.

Top module: `sclk_cs_ctrl`

## Requirements
- R1: After reset, `busy`, `byte_done`, `launch_stb` and `sample_stb` are 0, both `cs_n` lines are 1, and `sclk` equals `cpol`.
- R2: Divisor code n (0 to 7) gives an `sclk` half period of 2^n reference cycles. One byte lasts 16·2^n cycles, from the cycle `busy` rises to the cycle `byte_done` pulses, and `sclk` makes exactly 16 transitions in that time.
- R3: Whenever no byte is running, `sclk` sits at the `cpol` level sampled one cycle earlier. A byte also ends with `sclk` back at that level.
- R4: With `cpha`=0, `sample_stb` pulses on the 8 leading edges and `launch_stb` pulses on the 7 trailing edges other than the last. With `cpha`=1, `launch_stb` pulses on the 8 leading edges and `sample_stb` on the 8 trailing edges. A leading edge is a move away from the idle level. Each strobe is high in the first cycle that `sclk` shows its new level, and the two strobes are never high together.
- R5: With `man_cs_en`=0, the addressed select line is low exactly while `busy` is 1.
- R6: With `man_cs_en`=1, the addressed select line equals `cs_level`, so 0 asserts it, whatever the transfer state.
- R7: With `dual_mem`=1, `upper_sel`=1 addresses `cs_n[1]` and `upper_sel`=0 addresses `cs_n[0]`. With `dual_mem`=0, only `cs_n[0]` is ever addressed. The select line that is not addressed stays at 1.
- R8: With `man_start_en`=1, no byte starts until `start_pulse` is seen; a byte may start in the same cycle as the pulse. After a pulse, bytes keep starting while `byte_req` stays high. Once the block is idle with `byte_req` low, it waits for a new pulse.
- R9: While `enable`=0 or `master_en`=0, no byte starts. Dropping `enable` during a byte ends it at the next edge: `busy` falls, no `byte_done` is given, and `sclk` returns to `cpol`.
- R10: A change of `div_code` during a byte does not alter that byte. The new code applies to the next byte.
- R11: `byte_done` is a single-cycle pulse. It is raised in the same cycle that `busy` falls at the end of a completed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Global enable; 0 stops all activity |
| master_en | input | 1 | Master operation allowed |
| div_code | input | 3 | Prescaler code n, ratio 2^(n+1) |
| cpol | input | 1 | Idle level of sclk |
| cpha | input | 1 | Phase: 0 samples on leading edges, 1 on trailing |
| man_cs_en | input | 1 | Select driven from cs_level instead of transfer state |
| cs_level | input | 1 | Manual select level, 0 asserts |
| man_start_en | input | 1 | Hold bytes until start_pulse |
| start_pulse | input | 1 | Release queued bytes in manual-start mode |
| dual_mem | input | 1 | Two memories connected |
| upper_sel | input | 1 | Address the upper memory when dual_mem is set |
| byte_req | input | 1 | Shift engine has a byte queued |
| sclk | output | 1 | Serial clock |
| cs_n | output | 2 | Active-low selects; bit 0 lower memory, bit 1 upper |
| launch_stb | output | 1 | Shift engine drives the next bit |
| sample_stb | output | 1 | Shift engine captures the input bit |
| busy | output | 1 | A byte is being shifted |
| byte_done | output | 1 | A byte completed |

## Verification
`busy` rises one cycle after the edge that sees a byte allowed to start. Each `sclk` transition comes 2^n cycles after the previous one, or after that start, and its strobe is high in the same cycle. `byte_done` arrives 16·2^n cycles after `busy` rises, and `sclk` returns to its idle level one cycle after `cpol` changes. A monitor samples every output on the falling clock edge. It measures each byte's length, the transition intervals and the strobe placement against an expected item queued by the driver when the byte was requested. Select levels, manual-start holds and enable effects are checked directly by the driver, in the first falling-edge sample after the edge on which each is due.

// File: rtl/sclk_cs_pkg.sv
package sclk_cs_pkg;

    localparam int DIV_W     = 3;
    localparam int HALF_W    = (2 ** DIV_W) - 1;
    localparam int BYTE_BITS = 8;
    localparam int CS_LINES  = 2;

    // transfer format captured at byte start
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             cpol;
        logic             cpha;
    } xfer_mode_t;

    // reference cycles per sclk half period, minus one
    function automatic logic [HALF_W-1:0] half_limit(input logic [DIV_W-1:0] code);
        return HALF_W'((32'd1 << code) - 32'd1);
    endfunction

endpackage

// File: rtl/scc_start_gate.sv
module scc_start_gate (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic master_en,
    input  logic byte_req,
    input  logic man_start_en,
    input  logic start_pulse,
    input  logic busy,
    output logic start
);

    logic go_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            go_q <= 1'b0;
        end else if (!man_start_en) begin
            go_q <= 1'b0;
        end else if (start_pulse) begin
            go_q <= 1'b1;
        end else if (!busy && !byte_req) begin
            go_q <= 1'b0;
        end
    end

    always_comb begin
        start = enable && master_en && byte_req && !busy
                && (!man_start_en || go_q || start_pulse);
    end

endmodule

// File: rtl/scc_clock_gen.sv
module scc_clock_gen
    import sclk_cs_pkg::*;
#(
    parameter int BITS   = BYTE_BITS,
    localparam int EDGES  = 2 * BITS,
    localparam int EDGE_W = $clog2(EDGES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              start,
    input  xfer_mode_t        mode_in,
    output logic              busy,
    output logic              sclk,
    output logic              tick,
    output logic              last_edge,
    output logic [EDGE_W-1:0] edge_idx,
    output logic              done,
    output xfer_mode_t        mode_q
);

    logic [HALF_W-1:0] cnt_q;

    always_comb begin
        tick      = busy && (cnt_q == half_limit(mode_q.div));
        last_edge = (edge_idx == EDGE_W'(EDGES - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cnt_q    <= '0;
            edge_idx <= '0;
            mode_q   <= '0;
            sclk     <= mode_in.cpol;
            done     <= 1'b0;
        end else if (!enable) begin
            busy     <= 1'b0;
            cnt_q    <= '0;
            edge_idx <= '0;
            sclk     <= mode_in.cpol;
            done     <= 1'b0;
        end else if (!busy) begin
            cnt_q    <= '0;
            edge_idx <= '0;
            sclk     <= mode_in.cpol;
            done     <= 1'b0;
            if (start) begin
                busy   <= 1'b1;
                mode_q <= mode_in;
            end
        end else if (tick) begin
            cnt_q    <= '0;
            sclk     <= ~sclk;
            edge_idx <= edge_idx + EDGE_W'(1);
            done     <= last_edge;
            if (last_edge) begin
                busy <= 1'b0;
            end
        end else begin
            cnt_q <= cnt_q + HALF_W'(1);
            done  <= 1'b0;
        end
    end

    AST_DIV_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (mode_q == $past(mode_q))); // R10

    AST_ENABLE_STOPS: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !busy); // R9

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> (sclk == $past(mode_in.cpol))); // R3

endmodule

// File: rtl/scc_strobe.sv
module scc_strobe #(
    parameter int EDGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              tick,
    input  logic              last_edge,
    input  logic [EDGE_W-1:0] edge_idx,
    input  logic              cpha,
    output logic              launch_stb,
    output logic              sample_stb
);

    logic leading;
    logic launch_nx;
    logic sample_nx;

    always_comb begin
        leading = !edge_idx[0];
        if (cpha) begin
            launch_nx = tick && leading;
            sample_nx = tick && !leading;
        end else begin
            launch_nx = tick && !leading && !last_edge;
            sample_nx = tick && leading;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            launch_stb <= 1'b0;
            sample_stb <= 1'b0;
        end else begin
            launch_stb <= launch_nx;
            sample_stb <= sample_nx;
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(launch_stb && sample_stb)); // R4

endmodule

// File: rtl/scc_select.sv
module scc_select #(
    parameter int LINES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy,
    input  logic             man_cs_en,
    input  logic             cs_level,
    input  logic             dual_mem,
    input  logic             upper_sel,
    output logic [LINES-1:0] cs_n
);

    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

    logic             active;
    logic [IDX_W-1:0] target;

    always_comb begin
        active = man_cs_en ? !cs_level : busy;
        target = (dual_mem && upper_sel) ? IDX_W'(LINES - 1) : '0;
    end

    for (genvar gi = 0; gi < LINES; gi++) begin : g_line
        assign cs_n[gi] = !(active && (target == IDX_W'(gi)));
    end

    AST_CS_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n) <= 1); // R7

endmodule

// File: rtl/sclk_cs_ctrl.sv
module sclk_cs_ctrl
    import sclk_cs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic                master_en,
    input  logic [DIV_W-1:0]    div_code,
    input  logic                cpol,
    input  logic                cpha,
    input  logic                man_cs_en,
    input  logic                cs_level,
    input  logic                man_start_en,
    input  logic                start_pulse,
    input  logic                dual_mem,
    input  logic                upper_sel,
    input  logic                byte_req,
    output logic                sclk,
    output logic [CS_LINES-1:0] cs_n,
    output logic                launch_stb,
    output logic                sample_stb,
    output logic                busy,
    output logic                byte_done
);

    localparam int EDGE_W = $clog2(2 * BYTE_BITS);

    xfer_mode_t        mode_in;
    xfer_mode_t        mode_q;
    logic              start;
    logic              tick;
    logic              last_edge;
    logic [EDGE_W-1:0] edge_idx;

    always_comb begin
        mode_in.div  = div_code;
        mode_in.cpol = cpol;
        mode_in.cpha = cpha;
    end

    scc_start_gate u_gate (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .master_en    (master_en),
        .byte_req     (byte_req),
        .man_start_en (man_start_en),
        .start_pulse  (start_pulse),
        .busy         (busy),
        .start        (start)
    );

    scc_clock_gen #(.BITS(BYTE_BITS)) u_clk (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .start     (start),
        .mode_in   (mode_in),
        .busy      (busy),
        .sclk      (sclk),
        .tick      (tick),
        .last_edge (last_edge),
        .edge_idx  (edge_idx),
        .done      (byte_done),
        .mode_q    (mode_q)
    );

    scc_strobe #(.EDGE_W(EDGE_W)) u_stb (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .tick       (tick),
        .last_edge  (last_edge),
        .edge_idx   (edge_idx),
        .cpha       (mode_q.cpha),
        .launch_stb (launch_stb),
        .sample_stb (sample_stb)
    );

    scc_select #(.LINES(CS_LINES)) u_sel (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .man_cs_en (man_cs_en),
        .cs_level  (cs_level),
        .dual_mem  (dual_mem),
        .upper_sel (upper_sel),
        .cs_n      (cs_n)
    );

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        byte_done |=> !byte_done); // R11

    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (rst)
        byte_done |-> !busy); // R11

    AST_CS_AUTO: assert property (@(posedge clk) disable iff (rst)
        (!man_cs_en && busy) |-> (cs_n != '1)); // R5

    AST_NO_START_OFF: assert property (@(posedge clk) disable iff (rst)
        (!busy && !master_en) |=> !busy); // R9

endmodule

// File: tb/sclk_cs_ctrl_tb_top.sv
module sclk_cs_ctrl_tb_top;

    typedef struct {
        int    len;
        int    launches;
        int    samples;
        int    lead_samples;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b1;
    logic       master_en = 1'b1;
    logic [2:0] div_code = 3'd0;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;
    logic       man_cs_en = 1'b0;
    logic       cs_level = 1'b1;
    logic       man_start_en = 1'b0;
    logic       start_pulse = 1'b0;
    logic       dual_mem = 1'b0;
    logic       upper_sel = 1'b0;
    logic       byte_req = 1'b0;
    logic       sclk;
    logic [1:0] cs_n;
    logic       launch_stb;
    logic       sample_stb;
    logic       busy;
    logic       byte_done;

    int   n_checks = 0;
    int   n_fail = 0;
    int   cyc = 0;
    bit   finished = 1'b0;
    exp_t sb_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sclk_cs_ctrl dut_i (
        .clk(clk), .rst(rst), .enable(enable), .master_en(master_en),
        .div_code(div_code), .cpol(cpol), .cpha(cpha), .man_cs_en(man_cs_en),
        .cs_level(cs_level), .man_start_en(man_start_en), .start_pulse(start_pulse),
        .dual_mem(dual_mem), .upper_sel(upper_sel), .byte_req(byte_req),
        .sclk(sclk), .cs_n(cs_n), .launch_stb(launch_stb), .sample_stb(sample_stb),
        .busy(busy), .byte_done(byte_done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- monitor: measures each byte, pops expected item
    bit in_byte = 0;
    int t0, last_t, nl, ns, nlead, nt, min_i, max_i;
    logic idle_lvl, prev_sclk, prev_done = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (byte_done && prev_done) check(1'b0, "R11 done width", 2, 1);
            prev_done = byte_done;
            if (busy && !in_byte) begin
                in_byte = 1; t0 = cyc; last_t = cyc;
                nl = 0; ns = 0; nlead = 0; nt = 0; min_i = 1 << 30; max_i = 0;
                idle_lvl = sclk; prev_sclk = sclk;
            end
            if (in_byte) begin
                if (sclk != prev_sclk) begin
                    nt++;
                    if (cyc - last_t < min_i) min_i = cyc - last_t;
                    if (cyc - last_t > max_i) max_i = cyc - last_t;
                    last_t = cyc; prev_sclk = sclk;
                end
                if (launch_stb) nl++;
                if (sample_stb) begin
                    ns++;
                    if (sclk != idle_lvl) nlead++;
                end
                if (byte_done) begin
                    if (sb_q.size() == 0) begin
                        check(1'b0, "R2 unexpected byte", 1, 0);
                    end else begin
                        exp_t e;
                        e = sb_q.pop_front();
                        check(cyc - t0 == e.len, {"R2 length ", e.tag}, cyc - t0, e.len);
                        check(nt == 16, {"R2 transitions ", e.tag}, nt, 16);
                        check(min_i == e.len / 16 && max_i == e.len / 16,
                              {"R2 half period ", e.tag}, max_i, e.len / 16);
                        check(nl == e.launches, {"R4 launches ", e.tag}, nl, e.launches);
                        check(ns == e.samples, {"R4 samples ", e.tag}, ns, e.samples);
                        check(nlead == e.lead_samples, {"R4 leading samples ", e.tag},
                              nlead, e.lead_samples);
                        check(sclk == idle_lvl, {"R3 end level ", e.tag}, sclk, idle_lvl);
                        check(!busy, {"R11 busy with done ", e.tag}, busy, 0);
                    end
                    in_byte = 0;
                end else if (!busy) begin
                    in_byte = 0;
                end
            end
        end
    end

    // ---------------- driver
    task automatic wait_busy(input string tag);
        int g = 0;
        while (!busy && g < 100) begin @(negedge clk); g++; end
        check(busy, {tag, " byte started"}, busy, 1);
    endtask

    task automatic wait_idle();
        int g = 0;
        while (busy && g < 5000) begin @(negedge clk); g++; end
        repeat (2) @(negedge clk);
    endtask

    task automatic run_byte(input int n, input logic pol, input logic pha,
                            input logic [1:0] exp_cs, input string tag);
        exp_t e;
        @(negedge clk);
        div_code = 3'(n); cpol = pol; cpha = pha;
        repeat (2) @(negedge clk);
        check(sclk == pol, {"R3 idle ", tag}, sclk, pol);
        e.len = 16 << n; e.launches = pha ? 8 : 7; e.samples = 8;
        e.lead_samples = pha ? 0 : 8; e.tag = tag;
        sb_q.push_back(e);
        byte_req = 1'b1;
        @(negedge clk);
        wait_busy(tag);
        byte_req = 1'b0;
        check(cs_n == exp_cs, {"R5 R7 select ", tag}, cs_n, exp_cs);
        wait_idle();
        check(cs_n == 2'b11, {"R5 select released ", tag}, cs_n, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !byte_done && !launch_stb && !sample_stb, "R1 idle outputs", busy, 0);
        check(cs_n == 2'b11, "R1 selects", cs_n, 3);
        check(sclk == cpol, "R1 sclk", sclk, cpol);

        run_byte(0, 1'b0, 1'b0, 2'b10, "m0d0");
        run_byte(2, 1'b1, 1'b1, 2'b10, "m3d2");
        run_byte(1, 1'b0, 1'b1, 2'b10, "m1d1");
        run_byte(7, 1'b1, 1'b0, 2'b10, "m2d7");

        // R6 manual select
        man_cs_en = 1'b1; cs_level = 1'b0;
        @(negedge clk);
        check(cs_n == 2'b10, "R6 manual assert idle", cs_n, 2);
        cs_level = 1'b1;
        @(negedge clk);
        check(cs_n == 2'b11, "R6 manual release", cs_n, 3);
        run_byte(0, 1'b0, 1'b0, 2'b11, "R6 held high in byte");
        man_cs_en = 1'b0;

        // R7 steering
        dual_mem = 1'b1; upper_sel = 1'b1;
        run_byte(1, 1'b0, 1'b0, 2'b01, "R7 upper");
        upper_sel = 1'b0;
        run_byte(1, 1'b0, 1'b0, 2'b10, "R7 lower");
        dual_mem = 1'b0; upper_sel = 1'b1;
        run_byte(1, 1'b0, 1'b0, 2'b10, "R7 single");
        upper_sel = 1'b0;

        // R8 manual start
        begin
            exp_t e;
            div_code = 3'd0; cpol = 1'b0; cpha = 1'b0;
            man_start_en = 1'b1; byte_req = 1'b1;
            repeat (20) @(negedge clk);
            check(!busy, "R8 held before pulse", busy, 0);
            e.len = 16; e.launches = 7; e.samples = 8; e.lead_samples = 8; e.tag = "R8 pulse";
            sb_q.push_back(e);
            start_pulse = 1'b1;
            @(negedge clk);
            start_pulse = 1'b0;
            check(busy, "R8 start on pulse", busy, 1);
            byte_req = 1'b0;
            wait_idle();
            byte_req = 1'b1;
            repeat (10) @(negedge clk);
            check(!busy, "R8 rearm needs pulse", busy, 0);
            sb_q.push_back(e);
            man_start_en = 1'b0;
            @(negedge clk);
            check(busy, "R8 release by mode off", busy, 1);
            byte_req = 1'b0;
            wait_idle();
        end

        // R9 enable gating and abort
        enable = 1'b0; byte_req = 1'b1;
        repeat (10) @(negedge clk);
        check(!busy, "R9 disabled no start", busy, 0);
        byte_req = 1'b0; enable = 1'b1;
        master_en = 1'b0; byte_req = 1'b1;
        repeat (10) @(negedge clk);
        check(!busy, "R9 master off no start", busy, 0);
        byte_req = 1'b0; master_en = 1'b1;
        div_code = 3'd3; cpol = 1'b1;
        repeat (2) @(negedge clk);
        byte_req = 1'b1;
        @(negedge clk);
        wait_busy("R9 abort");
        byte_req = 1'b0;
        repeat (20) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(!busy, "R9 abort busy", busy, 0);
        check(sclk == 1'b1, "R9 abort sclk idle", sclk, 1);
        check(!byte_done, "R9 abort no done", byte_done, 0);
        enable = 1'b1;
        repeat (2) @(negedge clk);

        // R10 divisor change mid byte
        begin
            exp_t e;
            div_code = 3'd1; cpol = 1'b0; cpha = 1'b1;
            repeat (2) @(negedge clk);
            e.len = 32; e.launches = 8; e.samples = 8; e.lead_samples = 0; e.tag = "R10 change";
            sb_q.push_back(e);
            byte_req = 1'b1;
            @(negedge clk);
            wait_busy("R10");
            byte_req = 1'b0;
            div_code = 3'd3;
            wait_idle();
        end
        run_byte(3, 1'b0, 1'b1, 2'b10, "R10 next byte");

        check(sb_q.size() == 0, "R2 all bytes seen", sb_q.size(), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule